// File: doc/BRIEF.md
# Indirect Block-Pointer RAM Access Controller

This block gives a host processor access to a pointer RAM with one entry per buffer block. Each entry holds the index of the next block in a chained transmit buffer. The host cannot address the RAM directly. It programs a selection word that names a block and a direction, and that write starts the access. It then polls a busy flag until the access is done. A separate data word carries the value in both directions. A completed read leaves the RAM entry in the data word. A write commits whatever the data word holds at the moment the access runs.

The RAM has a single port, and the host shares it with a datapath read port. Every host access waits through a fixed countdown and then enters an arbitration cycle. The datapath wins any cycle in which it also requests, so each such cycle delays the host by one clock. Because the datapath reads the chain pointers from this RAM, any block can be made the starting block or a link of a chain by writing its entry.

Top module: `ptr_indirect_ctrl`

## Requirements
- R1: After reset the selection word and the data word read 0x0000, busy is 0 and dp_valid is 0.
- R2: The selection word (host offset 0) holds the block index in bits 9:0, the direction in bit 14 (1 = read, 0 = write) and the busy flag in bit 15. Bits 13:10 always read 0, and host writes to bits 15:10 other than bit 14 have no effect.
- R3: A selection write with direction 1 loads the RAM entry at the selected index into the data word by the time busy returns to 0.
- R4: A selection write with direction 0 stores the data word's value into the RAM entry at the selected index.
- R5: When the datapath does not request, busy reads 1 in the three clock cycles after the cycle in which the selection write is sampled, and reads 0 from the fourth cycle on.
- R6: The datapath port has priority. Each cycle in which dp_req is 1 while the host access is ready to use the RAM delays completion by one cycle. A datapath request returns the RAM entry at dp_addr on dp_rdata, with dp_valid at 1, in the next cycle.
- R7: A selection write that arrives while busy is 1 is ignored. The index, direction and operation in flight stay unchanged, and no second access starts.
- R8: A data-word write that arrives while busy is 1 is discarded. Read results and written values are not altered.
- R9: Indexes 0x000, 0x1FF and 0x3FF address distinct RAM entries, which keep independent values.
- R10: The data word (host offset 1) takes bits 9:0 of a host write and reads 0 in bits 15:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hwe | input | 1 | Host write enable |
| haddr | input | 2 | Host word offset (0 selection, 1 data) |
| hwdata | input | 16 | Host write data |
| hrdata | output | 16 | Host read data for the word at haddr |
| dp_req | input | 1 | Datapath pointer read request |
| dp_addr | input | 10 | Datapath block index |
| dp_valid | output | 1 | Datapath read result valid |
| dp_rdata | output | 10 | Datapath read result |

## Verification
The bench counts busy cycle by cycle after each selection write. A sequencer that is off by one in its countdown, or that grants the host while the datapath is requesting, shows a busy pattern that is too short or too long. A second selection write is issued during busy, pointed at an entry with a known value. If it were accepted, that entry would be overwritten and the readback of the selection word would show the wrong index. Data-word writes are made during both a busy read and a busy write. A design that lets them through would return a corrupted pointer or commit the wrong value. The entries at indexes 0x000, 0x1FF and 0x3FF are read back, which catches index truncation or aliasing at the ends of the range.

// File: rtl/ptr_ind_pkg.sv
package ptr_ind_pkg;

  localparam int unsigned BUS_W    = 16;
  localparam int unsigned DIR_BIT  = 14;
  localparam int unsigned BUSY_BIT = 15;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_ARB  = 2'd2
  } seq_state_e;

  // mask of the low w bits of a bus word
  function automatic logic [BUS_W-1:0] low_mask(input int unsigned w);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < BUS_W; i++) begin
      if (i < w) m[i] = 1'b1;
    end
    return m;
  endfunction

  // compose the selection word from its fields
  function automatic logic [BUS_W-1:0] pack_sel(input logic busy, input logic dir,
                                                input logic [BUS_W-1:0] idx_ext,
                                                input int unsigned w);
    logic [BUS_W-1:0] v;
    v = idx_ext & low_mask(w);
    v[DIR_BIT]  = dir;
    v[BUSY_BIT] = busy;
    return v;
  endfunction

endpackage

// File: rtl/ptr_host_regs.sv
module ptr_host_regs
  import ptr_ind_pkg::*;
#(
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned HADDR_W = 2,
  parameter int unsigned SEL_OFF = 0,
  parameter int unsigned DAT_OFF = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hwe,
  input  logic [HADDR_W-1:0] haddr,
  input  logic [BUS_W-1:0]   hwdata,
  output logic [BUS_W-1:0]   hrdata,
  input  logic               busy,
  input  logic               ld_en,
  input  logic [IDX_W-1:0]   ld_val,
  output logic [IDX_W-1:0]   idx_q,
  output logic               dir_q,
  output logic [IDX_W-1:0]   dat_q,
  output logic               start_acc,
  output logic               sel_wr_drop,
  output logic               dat_wr_drop
);

  localparam logic [HADDR_W-1:0] SEL_A = HADDR_W'(SEL_OFF);
  localparam logic [HADDR_W-1:0] DAT_A = HADDR_W'(DAT_OFF);

  logic sel_hit;
  logic dat_hit;
  logic dat_take;
  logic unused_hw;

  assign sel_hit     = hwe && (haddr == SEL_A);
  assign dat_hit     = hwe && (haddr == DAT_A);
  assign start_acc   = sel_hit && !busy;
  assign sel_wr_drop = sel_hit && busy;
  assign dat_take    = dat_hit && !busy;
  assign dat_wr_drop = dat_hit && busy;
  assign unused_hw   = ^hwdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      dir_q <= 1'b0;
    end else if (start_acc) begin
      idx_q <= hwdata[IDX_W-1:0];
      dir_q <= hwdata[DIR_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (ld_en) begin
      dat_q <= ld_val;
    end else if (dat_take) begin
      dat_q <= hwdata[IDX_W-1:0];
    end
  end

  always_comb begin
    hrdata = '0;
    if (haddr == SEL_A) begin
      hrdata = pack_sel(busy, dir_q, BUS_W'(idx_q), IDX_W);
    end else if (haddr == DAT_A) begin
      hrdata = BUS_W'(dat_q);
    end
  end

endmodule

// File: rtl/ptr_access_seq.sv
module ptr_access_seq
  import ptr_ind_pkg::*;
#(
  parameter int unsigned ACC_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_acc,
  input  logic dp_req,
  output logic busy,
  output logic host_gnt,
  output logic acc_done
);

  localparam int unsigned CNT_W = (ACC_LAT < 2) ? 1 : $clog2(ACC_LAT + 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy     = (state_q != SQ_IDLE);
  assign host_gnt = (state_q == SQ_ARB) && !dp_req;
  assign acc_done = host_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start_acc) begin
            if (ACC_LAT > 1) begin
              state_q <= SQ_WAIT;
              cnt_q   <= CNT_W'(ACC_LAT - 1);
            end else begin
              state_q <= SQ_ARB;
            end
          end
        end
        SQ_WAIT: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= SQ_ARB;
        end
        SQ_ARB: begin
          if (host_gnt) state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ptr_ram_sp.sv
module ptr_ram_sp #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_req,
  input  logic [IDX_W-1:0] dp_addr,
  input  logic             host_gnt,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [IDX_W-1:0] host_wdata,
  output logic [IDX_W-1:0] port_q,
  output logic             dp_valid,
  output logic [IDX_W-1:0] dp_rdata
);

  logic [IDX_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] port_addr;

  assign port_addr = dp_req ? dp_addr : host_idx;
  assign port_q    = mem[port_addr];

  always_ff @(posedge clk) begin
    if (host_gnt && host_we) mem[host_idx] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_rdata <= '0;
    end else begin
      dp_valid <= dp_req;
      if (dp_req) dp_rdata <= port_q;
    end
  end

endmodule

// File: rtl/ptr_indirect_ctrl.sv
module ptr_indirect_ctrl
  import ptr_ind_pkg::*;
#(
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned HADDR_W = 2,
  parameter int unsigned SEL_OFF = 0,
  parameter int unsigned DAT_OFF = 1,
  parameter int unsigned ACC_LAT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hwe,
  input  logic [HADDR_W-1:0] haddr,
  input  logic [15:0]        hwdata,
  output logic [15:0]        hrdata,
  input  logic               dp_req,
  input  logic [IDX_W-1:0]   dp_addr,
  output logic               dp_valid,
  output logic [IDX_W-1:0]   dp_rdata
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic             busy;
  logic             start_acc;
  logic             host_gnt;
  logic             acc_done;
  logic             sel_wr_drop;
  logic             dat_wr_drop;
  logic             ld_en;
  logic [IDX_W-1:0] idx_q;
  logic             dir_q;
  logic [IDX_W-1:0] dat_q;
  logic [IDX_W-1:0] ram_q;

  assign ld_en = acc_done && dir_q;

  ptr_host_regs #(
    .IDX_W(IDX_W), .HADDR_W(HADDR_W), .SEL_OFF(SEL_OFF), .DAT_OFF(DAT_OFF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .hwe(hwe), .haddr(haddr), .hwdata(hwdata),
    .hrdata(hrdata), .busy(busy), .ld_en(ld_en), .ld_val(ram_q),
    .idx_q(idx_q), .dir_q(dir_q), .dat_q(dat_q), .start_acc(start_acc),
    .sel_wr_drop(sel_wr_drop), .dat_wr_drop(dat_wr_drop)
  );

  ptr_access_seq #(.ACC_LAT(ACC_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .dp_req(dp_req),
    .busy(busy), .host_gnt(host_gnt), .acc_done(acc_done)
  );

  ptr_ram_sp #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .dp_req(dp_req), .dp_addr(dp_addr),
    .host_gnt(host_gnt), .host_we(!dir_q), .host_idx(idx_q),
    .host_wdata(dat_q), .port_q(ram_q), .dp_valid(dp_valid), .dp_rdata(dp_rdata)
  );

endmodule

// File: rtl/ptr_indirect_chk.sv
module ptr_indirect_chk #(
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned HADDR_W = 2,
  parameter int unsigned SEL_OFF = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               start_acc,
  input logic               host_gnt,
  input logic               acc_done,
  input logic               dp_req,
  input logic               sel_wr_drop,
  input logic               dat_wr_drop,
  input logic [IDX_W-1:0]   idx_q,
  input logic               dir_q,
  input logic [IDX_W-1:0]   dat_q,
  input logic [IDX_W-1:0]   ram_q,
  input logic               dp_valid,
  input logic [HADDR_W-1:0] haddr,
  input logic [15:0]        hrdata
);

  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_acc));

  assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(acc_done));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !busy);

  assert_dp_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_gnt && dp_req));

  assert_dp_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dp_req |=> dp_valid);

  assert_dp_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_req |=> !dp_valid);

  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_drop |=> ($stable(idx_q) && $stable(dir_q)));

  assert_dat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr_drop && !acc_done) |=> $stable(dat_q));

  assert_rd_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && dir_q) |=> (dat_q == $past(ram_q)));

  assert_sel_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (haddr == HADDR_W'(SEL_OFF)) |-> (hrdata[13:IDX_W] == '0));

endmodule

bind ptr_indirect_ctrl ptr_indirect_chk #(
  .IDX_W(IDX_W), .HADDR_W(HADDR_W), .SEL_OFF(SEL_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start_acc(start_acc),
  .host_gnt(host_gnt), .acc_done(acc_done), .dp_req(dp_req),
  .sel_wr_drop(sel_wr_drop), .dat_wr_drop(dat_wr_drop), .idx_q(idx_q),
  .dir_q(dir_q), .dat_q(dat_q), .ram_q(ram_q), .dp_valid(dp_valid),
  .haddr(haddr), .hrdata(hrdata)
);

// File: tb/ptr_indirect_ctrl_test.sv
`timescale 1ns/1ps
module ptr_indirect_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_SEL = 2'd0;
  localparam logic [1:0] A_DAT = 2'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hwe = 1'b0;
  logic [1:0]  haddr = 2'd0;
  logic [15:0] hwdata = 16'h0;
  logic [15:0] hrdata;
  logic        dp_req = 1'b0;
  logic [9:0]  dp_addr = 10'h0;
  logic        dp_valid;
  logic [9:0]  dp_rdata;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  logic [9:0] model [int];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  event        probe_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_indirect_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hwe(hwe), .haddr(haddr), .hwdata(hwdata),
    .hrdata(hrdata), .dp_req(dp_req), .dp_addr(dp_addr),
    .dp_valid(dp_valid), .dp_rdata(dp_rdata)
  );

  function automatic logic [15:0] sel_word(input logic b, input logic d, input logic [9:0] i);
    return {b, d, 4'b0000, i};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares host reads against the scoreboard queue
  initial begin
    forever begin
      @(probe_ev);
      while (exp_q.size() > 0) begin
        check(tag_q.pop_front(), hrdata, exp_q.pop_front());
      end
    end
  end

  task automatic probe(input logic [1:0] a, input logic [15:0] exp, input string tag);
    haddr = a;
    #1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    -> probe_ev;
    #1;
  endtask

  task automatic sel_write(input logic [15:0] w);
    hwe = 1'b1; haddr = A_SEL; hwdata = w;
    @(negedge clk);
    hwe = 1'b0;
  endtask

  task automatic dat_write(input logic [15:0] w);
    hwe = 1'b1; haddr = A_DAT; hwdata = w;
    @(negedge clk);
    hwe = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int k;
    k = 0;
    haddr = A_SEL;
    #1;
    while (hrdata[15] === 1'b1 && k < 40) begin
      @(negedge clk);
      #1;
      k++;
    end
    if (k >= 40) begin
      n_checks++; n_errors++;
      $display("FAIL %s: busy stuck actual 1 expected 0", tag);
    end
  endtask

  task automatic ind_write(input logic [9:0] idx, input logic [9:0] v, input string tag);
    dat_write({6'b0, v});
    sel_write({6'b0, idx});
    wait_idle(tag);
    @(negedge clk);
    model[int'(idx)] = v;
  endtask

  task automatic ind_read(input logic [9:0] idx, input string tag);
    sel_write({6'b0, idx} | 16'h4000);
    wait_idle(tag);
    @(negedge clk);
    probe(A_DAT, {6'b0, model[int'(idx)]}, tag);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    probe(A_SEL, 16'h0000, "R1 sel");
    probe(A_DAT, 16'h0000, "R1 dat");
    check("R1 dp_valid", {15'b0, dp_valid}, 16'h0000);

    // R10 data word width
    dat_write(16'hFFFF);
    probe(A_DAT, 16'h03FF, "R10 dat mask");
    dat_write(16'h0155);
    probe(A_DAT, 16'h0155, "R10 dat value");

    // R2 / R4 / R5: write with junk upper bits, busy timing
    sel_write(16'hBC05);
    probe(A_SEL, sel_word(1'b1, 1'b0, 10'h005), "R5 busy c1 R2");
    @(negedge clk);
    probe(A_SEL, sel_word(1'b1, 1'b0, 10'h005), "R5 busy c2");
    @(negedge clk);
    probe(A_SEL, sel_word(1'b1, 1'b0, 10'h005), "R5 busy c3");
    @(negedge clk);
    probe(A_SEL, sel_word(1'b0, 1'b0, 10'h005), "R5 idle c4 R2");
    model[5] = 10'h155;
    @(negedge clk);

    // R3 read timing: data present when busy drops
    sel_write(16'h4005);
    probe(A_SEL, sel_word(1'b1, 1'b1, 10'h005), "R5 read busy c1");
    @(negedge clk);
    @(negedge clk);
    probe(A_SEL, sel_word(1'b1, 1'b1, 10'h005), "R5 read busy c3");
    @(negedge clk);
    probe(A_SEL, sel_word(1'b0, 1'b1, 10'h005), "R5 read idle c4");
    probe(A_DAT, 16'h0155, "R3 read value");
    @(negedge clk);

    // R9 boundaries
    ind_write(10'h000, 10'h2A1, "R9 wr 000");
    ind_write(10'h1FF, 10'h0F7, "R9 wr 1FF");
    ind_write(10'h3FF, 10'h318, "R9 wr 3FF");
    ind_read(10'h000, "R9 rd 000");
    ind_read(10'h1FF, "R9 rd 1FF");
    ind_read(10'h3FF, "R9 rd 3FF");
    ind_read(10'h005, "R4 rd 005");

    // R7 selection write during busy is ignored
    ind_write(10'h020, 10'h0AA, "R7 pre");
    dat_write(16'h0333);
    sel_write(16'h41FF);
    sel_write(16'h0020);
    wait_idle("R7 wait");
    probe(A_SEL, sel_word(1'b0, 1'b1, 10'h1FF), "R7 sel kept");
    probe(A_DAT, {6'b0, model[32'h1FF]}, "R7 read result");
    @(negedge clk);
    ind_read(10'h020, "R7 entry intact");

    // R8 data write during busy read
    sel_write(16'h43FF);
    dat_write(16'h0111);
    wait_idle("R8 wait rd");
    probe(A_DAT, {6'b0, model[32'h3FF]}, "R8 read not corrupted");
    @(negedge clk);
    // R8 data write during busy write
    dat_write(16'h00F0);
    sel_write(16'h0030);
    dat_write(16'h0222);
    wait_idle("R8 wait wr");
    model[32'h30] = 10'h0F0;
    probe(A_DAT, 16'h00F0, "R8 dat kept");
    @(negedge clk);
    ind_read(10'h030, "R8 committed value");

    // R6 datapath priority
    dat_write(16'h01C3);
    sel_write(16'h0040);
    probe(A_SEL, sel_word(1'b1, 1'b0, 10'h040), "R6 busy c1");
    @(negedge clk);
    @(negedge clk);
    dp_req = 1'b1; dp_addr = 10'h005;
    probe(A_SEL, sel_word(1'b1, 1'b0, 10'h040), "R6 busy c3");
    @(negedge clk);
    check("R6 dp_valid", {15'b0, dp_valid}, 16'h0001);
    check("R6 dp_rdata", {6'b0, dp_rdata}, 16'h0155);
    probe(A_SEL, sel_word(1'b1, 1'b0, 10'h040), "R6 stall 1");
    @(negedge clk);
    dp_req = 1'b0;
    probe(A_SEL, sel_word(1'b1, 1'b0, 10'h040), "R6 stall 2");
    @(negedge clk);
    probe(A_SEL, sel_word(1'b0, 1'b0, 10'h040), "R6 done");
    check("R6 dp_valid low", {15'b0, dp_valid}, 16'h0000);
    model[32'h40] = 10'h1C3;
    @(negedge clk);
    ind_read(10'h040, "R6 host value");
    dp_req = 1'b1; dp_addr = 10'h3FF;
    @(negedge clk);
    dp_req = 1'b0;
    check("R6 dp 3FF", {6'b0, dp_rdata}, {6'b0, model[32'h3FF]});
    dp_req = 1'b1; dp_addr = 10'h040;
    @(negedge clk);
    dp_req = 1'b0;
    check("R6 dp 040", {6'b0, dp_rdata}, 16'h01C3);

    @(negedge clk);
    finish_run();
  end

endmodule